// File: doc/BRIEF.md
# Six-Channel Command and Fault-Report SPI Slave

This block is the serial front end of a six-channel low-side gate driver. A host controller runs SPI mode 1 transactions (clock idle low, data launched on the rising clock edge and sampled on the falling edge, most significant bit first). During each transaction the block receives an on/off command for every channel. On the same wires it returns a fault word that shows which channels report a problem. The frame length can be 8 or 16 bits, selected by a configuration input.

The serial pins are asynchronous to the block clock. They are synchronised and edge-detected in the clock domain. When chip select goes active, the block freezes the six live fault flags into its transmit shift register and latches the frame-length setting. When chip select returns high, it checks the number of falling clock edges seen. If the count matches the latched length, the low six received bits go to the command register that drives the gate logic. If the count is wrong, the frame is thrown away.

Top module: `spi_cf_top`

## Requirements
- R1: After reset `cmd_out` is all zero (every channel off), `sdo_oe` is 0 and `sdo` is 0.
- R2: `sdo_oe` is 1 only while `cs_n` is low. While `cs_n` is high, `sdo_oe` is 0 and `sdo` is held at 0.
- R3: The fault flags are captured once, when `cs_n` falls. Changes on `fault_in` after that point do not alter the report of the current frame.
- R4: The report is an L-bit word sent MSB first. Word bit i (i = 0..5) equals `fault_in[i]`, where 1 means the channel is faulted. All higher word bits are 0, and bits clocked beyond L read 0. `sdo` changes after each rising `sck` edge and is valid at the following falling edge.
- R5: `sdi` is sampled on each falling `sck` edge, MSB first. The last six bits received form the command, with word bit i the command for channel i (1 = on).
- R6: `cmd_out` changes only after `cs_n` rises. It keeps its old value for the whole frame.
- R7: A frame whose count of falling `sck` edges differs from L is discarded, and `cmd_out` keeps its previous value. This applies to both short and long counts.
- R8: L is taken from `frame_long` at the falling edge of `cs_n` (0 gives 8 bits, 1 gives 16 bits). Changing `frame_long` during a frame has no effect on that frame.
- R9: Received bits above bit 5 of the word are ignored and do not affect `cmd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than four times the SPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_long | input | 1 | Frame length select: 0 = 8 bits, 1 = 16 bits |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idles low |
| sdi | input | 1 | SPI data from host |
| sdo | output | 1 | SPI data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| fault_in | input | 6 | Live per-channel fault flags, 1 = faulted |
| cmd_out | output | 6 | Per-channel gate command, 1 = on |

## Verification
A corrupted bit counter or a wrongly latched length shows up at the end of the very next frame. Either a well-formed frame fails to reach `cmd_out`, or a malformed frame leaks through. A transmit register that is loaded at the wrong moment, or shifted too often, makes `sdo` disagree with the frozen fault word at the first affected falling edge. The check therefore compares every reported bit against a queue of expected values. `cmd_out` is checked mid-frame and again a few cycles after chip select rises, so a premature update is caught within the frame where it happens.

// File: rtl/spi_cf_pkg.sv
package spi_cf_pkg;

  // Synchronised serial pins
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
  } spi_pins_t;

  // Single-cycle events derived from the synchronised pins
  typedef struct packed {
    logic active;    // chip select asserted
    logic cs_fall;   // frame start
    logic cs_rise;   // frame end
    logic sck_rise;  // launch edge
    logic sck_fall;  // capture edge
  } spi_evt_t;

  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};

endpackage

// File: rtl/spi_cf_sync.sv
module spi_cf_sync #(
  parameter int unsigned           WIDTH   = 3,
  parameter int unsigned           STAGES  = 2,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_cf_edge.sv
module spi_cf_edge
  import spi_cf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t pins_i,
  output spi_evt_t  evt_o,
  output logic      sdi_o
);

  spi_pins_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PINS_IDLE;
    else        prev_q <= pins_i;
  end

  always_comb begin
    evt_o.active   = !pins_i.cs_n;
    evt_o.cs_fall  = prev_q.cs_n & !pins_i.cs_n;
    evt_o.cs_rise  = !prev_q.cs_n & pins_i.cs_n;
    evt_o.sck_rise = !pins_i.cs_n & !prev_q.sck & pins_i.sck;
    evt_o.sck_fall = !pins_i.cs_n & prev_q.sck & !pins_i.sck;
  end

  assign sdi_o = pins_i.sdi;

endmodule

// File: rtl/spi_cf_shifter.sv
module spi_cf_shifter
  import spi_cf_pkg::*;
#(
  parameter int unsigned NUM_CH     = 6,
  parameter int unsigned SHORT_BITS = 8,
  parameter int unsigned LONG_BITS  = 16,
  parameter int unsigned CNT_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  spi_evt_t             evt_i,
  input  logic                 sdi_i,
  input  logic                 frame_long_i,
  input  logic [NUM_CH-1:0]    fault_i,
  output logic                 sdo_o,
  output logic [LONG_BITS-1:0] rx_word_o,
  output logic [CNT_W-1:0]     bit_cnt_o,
  output logic                 len_long_o
);

  localparam int unsigned        PAD_SHIFT = LONG_BITS - SHORT_BITS;
  localparam logic [CNT_W-1:0]   CNT_MAX   = CNT_W'(LONG_BITS + 1);

  logic [LONG_BITS-1:0] tx_q, tx_d;
  logic [LONG_BITS-1:0] rx_q, rx_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 sdo_q, sdo_d;
  logic                 long_q, long_d;
  logic [LONG_BITS-1:0] flt_word;

  assign flt_word = LONG_BITS'(fault_i);

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    sdo_d  = sdo_q;
    long_d = long_q;
    if (evt_i.cs_fall) begin
      long_d = frame_long_i;
      tx_d   = frame_long_i ? flt_word : (flt_word << PAD_SHIFT);
      sdo_d  = 1'b0;
      cnt_d  = '0;
    end else if (evt_i.active) begin
      if (evt_i.sck_rise) begin
        sdo_d = tx_q[LONG_BITS-1];
        tx_d  = {tx_q[LONG_BITS-2:0], 1'b0};
      end
      if (evt_i.sck_fall) begin
        rx_d = {rx_q[LONG_BITS-2:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
      long_q <= long_d;
    end
  end

  assign sdo_o      = sdo_q;
  assign rx_word_o  = rx_q;
  assign bit_cnt_o  = cnt_q;
  assign len_long_o = long_q;

  // R3: the frozen report moves only on a frame start or a launch edge
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i.cs_fall && !evt_i.sck_rise |=> $stable(tx_q));

  // R5: received data moves only on a capture edge inside a frame
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_i.active && evt_i.sck_fall && !evt_i.cs_fall) |=> $stable(rx_q));

  // R7: the edge counter never wraps back into a valid length
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R8: latched length is frozen for the whole frame
  a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i.cs_fall |=> $stable(long_q));

endmodule

// File: rtl/spi_cf_cmd.sv
module spi_cf_cmd #(
  parameter int unsigned NUM_CH     = 6,
  parameter int unsigned SHORT_BITS = 8,
  parameter int unsigned LONG_BITS  = 16,
  parameter int unsigned CNT_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_rise_i,
  input  logic [CNT_W-1:0]     bit_cnt_i,
  input  logic                 len_long_i,
  input  logic [LONG_BITS-1:0] rx_word_i,
  output logic [NUM_CH-1:0]    cmd_o
);

  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_BITS);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_BITS);

  logic [NUM_CH-1:0] cmd_q, cmd_d;
  logic              len_ok;
  logic              commit_en;

  assign len_ok    = bit_cnt_i == (len_long_i ? LONG_CNT : SHORT_CNT);
  assign commit_en = cs_rise_i & len_ok;

  always_comb begin
    cmd_d = cmd_q;
    if (commit_en) cmd_d = rx_word_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  // R6: command output moves only at a frame end
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise_i |=> $stable(cmd_q));

  // R7: a frame end with a bad edge count leaves the command alone
  a_r7_bad_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i && (bit_cnt_i != SHORT_CNT) && (bit_cnt_i != LONG_CNT) |=> $stable(cmd_q));

endmodule

// File: rtl/spi_cf_top.sv
module spi_cf_top
  import spi_cf_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned SHORT_BITS  = 8,
  parameter int unsigned LONG_BITS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_long,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [NUM_CH-1:0] fault_in,
  output logic [NUM_CH-1:0] cmd_out
);

  localparam int unsigned CNT_W = $clog2(LONG_BITS + 2);

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  spi_pins_t            pins_raw, pins_sync;
  spi_evt_t             evt;
  logic                 sdi_s;
  logic                 sdo_q;
  logic [LONG_BITS-1:0] rx_word;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 len_long;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign pins_raw = '{cs_n: cs_n, sck: sck, sdi: sdi};

  spi_cf_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (pins_raw),
    .q_o  (pins_sync)
  );

  spi_cf_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pins_i(pins_sync),
    .evt_o (evt),
    .sdi_o (sdi_s)
  );

  spi_cf_shifter #(
    .NUM_CH    (NUM_CH),
    .SHORT_BITS(SHORT_BITS),
    .LONG_BITS (LONG_BITS),
    .CNT_W     (CNT_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_i       (evt),
    .sdi_i       (sdi_s),
    .frame_long_i(frame_long),
    .fault_i     (fault_in),
    .sdo_o       (sdo_q),
    .rx_word_o   (rx_word),
    .bit_cnt_o   (bit_cnt),
    .len_long_o  (len_long)
  );

  spi_cf_cmd #(
    .NUM_CH    (NUM_CH),
    .SHORT_BITS(SHORT_BITS),
    .LONG_BITS (LONG_BITS),
    .CNT_W     (CNT_W)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_rise_i (evt.cs_rise),
    .bit_cnt_i (bit_cnt),
    .len_long_i(len_long),
    .rx_word_i (rx_word),
    .cmd_o     (cmd_out)
  );

  assign sdo_oe = evt.active;
  assign sdo    = evt.active & sdo_q;

  // R2: the pad is never enabled on the cycle a frame has just closed
  a_r2_oe_off_after_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt.cs_rise |-> !sdo_oe);

endmodule

// File: tb/spi_cf_top_bench.sv
module spi_cf_top_bench;

  localparam int HALF = 8;  // clock cycles per SCK half period

  logic       clk;
  logic       rst_n;
  logic       frame_long;
  logic       cs_n;
  logic       sck;
  logic       sdi;
  logic       sdo;
  logic       sdo_oe;
  logic [5:0] fault_in;
  logic [5:0] cmd_out;

  int   n_tests;
  int   n_fail;
  logic exp_q[$];
  logic [5:0] cur_cmd;

  spi_cf_top u_spi_cf_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_long(frame_long),
    .cs_n      (cs_n),
    .sck       (sck),
    .sdi       (sdi),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .fault_in  (fault_in),
    .cmd_out   (cmd_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every reported bit at the capture edge
  always @(negedge sck) begin
    if (!cs_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected report bit", {31'd0, sdo}, 32'd0);
      end else begin
        logic e;
        e = exp_q.pop_front();
        chk(sdo === e, "R4", "report bit", {31'd0, sdo}, {31'd0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame; expected report bits go to the queue
  task automatic frame(input int nbits, input logic [31:0] word,
                       input logic cfg_long, input logic [5:0] flt,
                       input logic [5:0] flt_late, input bit flip_cfg,
                       input logic [5:0] exp_cmd);
    int L;
    logic [15:0] rep;
    L   = cfg_long ? 16 : 8;
    rep = {10'd0, flt};
    frame_long = cfg_long;
    fault_in   = flt;
    wait_clk(6);
    cs_n = 1'b0;
    wait_clk(HALF);
    chk(sdo_oe === 1'b1, "R2", "oe during frame", {31'd0, sdo_oe}, 32'd1);
    fault_in = flt_late;  // R3: change after the snapshot
    for (int k = 0; k < nbits; k++) begin
      exp_q.push_back(k < L ? rep[L-1-k] : 1'b0);
    end
    for (int k = 0; k < nbits; k++) begin
      sdi = word[nbits-1-k];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
      if (flip_cfg && k == 2) frame_long = ~cfg_long;  // R8
      if (k == nbits / 2)
        chk(cmd_out === cur_cmd, "R6", "cmd held mid-frame", {26'd0, cmd_out}, {26'd0, cur_cmd});
    end
    cs_n = 1'b1;
    wait_clk(HALF);
    chk(sdo_oe === 1'b0, "R2", "oe after frame", {31'd0, sdo_oe}, 32'd0);
    chk(sdo === 1'b0, "R2", "sdo after frame", {31'd0, sdo}, 32'd0);
    chk(exp_q.size() == 0, "R4", "report bits consumed", exp_q.size(), 32'd0);
    exp_q.delete();
    cur_cmd = exp_cmd;
    chk(cmd_out === exp_cmd, "R5", "cmd after frame", {26'd0, cmd_out}, {26'd0, exp_cmd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests    = 0;
    n_fail     = 0;
    cur_cmd    = 6'd0;
    rst_n      = 1'b0;
    cs_n       = 1'b1;
    sck        = 1'b0;
    sdi        = 1'b0;
    frame_long = 1'b0;
    fault_in   = 6'd0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    chk(cmd_out === 6'd0, "R1", "cmd after reset", {26'd0, cmd_out}, 32'd0);
    chk(sdo_oe === 1'b0, "R1", "oe after reset", {31'd0, sdo_oe}, 32'd0);
    chk(sdo === 1'b0, "R1", "sdo after reset", {31'd0, sdo}, 32'd0);

    // R5 R4: short frame
    frame(8, 32'h33, 1'b0, 6'b101101, 6'b101101, 1'b0, 6'b110011);
    // R9: long frame with ones in the non-channel bits
    frame(16, 32'hFFCA, 1'b1, 6'b010110, 6'b010110, 1'b0, 6'b001010);
    // R7: too few edges for a short frame
    frame(7, 32'h3F, 1'b0, 6'b000001, 6'b000001, 1'b0, 6'b001010);
    // R7: too many edges for a long frame
    frame(17, 32'h1FFFF, 1'b1, 6'b100000, 6'b100000, 1'b0, 6'b001010);
    // R7: long count while short selected
    frame(16, 32'h003F, 1'b0, 6'b000000, 6'b000000, 1'b0, 6'b001010);
    // R3: faults change right after the frame start
    frame(8, 32'h15, 1'b0, 6'b111000, 6'b000111, 1'b0, 6'b010101);
    // R8: short selected then flipped to long mid-frame
    frame(8, 32'h2A, 1'b0, 6'b000011, 6'b000011, 1'b1, 6'b101010);
    // R8: long selected then flipped to short mid-frame
    frame(16, 32'h8007, 1'b1, 6'b110000, 6'b110000, 1'b1, 6'b000111);
    // R4 R5: all faults, all channels off
    frame(8, 32'hC0, 1'b0, 6'b111111, 6'b111111, 1'b0, 6'b000000);
    // R5: all channels on through a long frame
    frame(16, 32'h003F, 1'b1, 6'b000000, 6'b111111, 1'b0, 6'b111111);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule